// File: doc/BRIEF.md
# Block Cipher Register Front End and Block Sequencer

This block is the host-facing side of a 64-bit block cipher engine. It gives software a 32-bit register window for the key, chaining vector, mode, data and request length. It then paces the work one block at a time. The host or a DMA channel writes two data words. The block hands the 64-bit block to a cipher core through a start/done port. The result is then held in the same data window for reading. The cipher core itself is outside this block.

Chaining mode is handled in the front end. In CBC encryption the block is XORed with the chaining vector before it goes to the core, and the core result becomes the new vector. In CBC decryption the core result is XORed with the vector, and the ciphertext that went in becomes the new vector. The vector registers always hold the current chaining value, so software can read it back to continue a later request.

A byte length arms the sequencer. Each block read out uses up eight bytes. Two interrupt events mark the phases: one when the block can accept input and one when output is ready. Both events also drive DMA request lines once DMA is enabled.

Top module: `cipher_reg_front`

## Requirements
- R1: After reset, every register reads zero except the revision, and `irq`, `core_start` and both DMA requests are low.
- R2: Key word i (0..5) sits at byte address 0x14 − ((i XOR 1)·4), which gives word0 at 0x10, word1 at 0x14, word2 at 0x08, word3 at 0x0C, word4 at 0x00 and word5 at 0x04. Each word reads back from its address and drives `core_key[32i+31:32i]`.
- R3: Control register 0x20: bit 4 selects CBC (0 selects ECB), bit 3 selects triple-key, and bit 2 selects encrypt. These three bits are writable. Bit 1 (input ready) and bit 0 (output ready) are read-only status, and writes to them have no effect.
- R4: A write to 0x24 sets the remaining byte count with the low three bits forced to zero. Reading 0x24 returns the remaining count, which drops by 8 each time a block's second output word is read.
- R5: Input ready is set while the remaining count is nonzero and no block is in flight. Data word 0x28 supplies block bits 63:32 and 0x2C supplies bits 31:0. Writing 0x2C while input is ready gives a single-cycle `core_start` on the next cycle.
- R6: In ECB mode the data window returns the core result unchanged. Output ready rises on the core's done pulse and clears when 0x2C is read.
- R7: In CBC encryption the core input is the block XOR the chaining vector (0x18 = bits 63:32, 0x1C = bits 31:0). After the block the vector equals the core result.
- R8: In CBC decryption the output is the core result XOR the vector. After the block the vector equals the ciphertext block that was written.
- R9: Interrupt status 0x3C bit 1 sets when input ready rises, and bit 2 sets on the core's done pulse. Bit 2 also clears when 0x2C is read. A status write clears every bit written as 0. `irq` is high when any status bit is set with its enable bit at 0x40 set.
- R10: DMA register 0x34: bit 0 is start, bit 5 enables the input request and bit 6 enables the output request. `dma_in_req` equals start AND bit 5 AND input ready, and `dma_out_req` equals start AND bit 6 AND output ready. Clearing the register drops both requests.
- R11: Writes to the data window while input is not ready are ignored. They change neither the result nor the chaining vector of the block in flight.
- R12: Revision register 0x30 reads 0x00000305 (major 3 in bits 10:8, minor 5 in bits 5:0) and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for read side effects) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt line |
| dma_in_req | output | 1 | DMA request for an input block |
| dma_out_req | output | 1 | DMA request for an output block |
| core_start | output | 1 | Single-cycle start to the cipher core |
| core_key | output | 192 | Six key words, word i at bits 32i+31:32i |
| core_triple | output | 1 | Triple-key select |
| core_encrypt | output | 1 | Direction, 1 = encrypt |
| core_din | output | 64 | Block presented to the core |
| core_done | input | 1 | Core result valid pulse |
| core_dout | input | 64 | Core result |

## Verification
On every cycle, assertions check several rules. A start only occurs while the sequencer is running a block. Output ready and the data-out event can only rise after a done pulse. The remaining count only moves in steps of eight unless it was just written. The key, the chaining vector and the held input block stay stable when nothing allowed them to change. The bench scenarios with a stub core cover the rest. These include the arithmetic of CBC chaining across two blocks in both directions, the pair-swapped key addresses, and the interrupt and DMA request levels during the in/out phases. They also cover ignored writes during a block in flight and the rounding of the length.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int DW        = 32;
    localparam int BLK_W     = 64;
    localparam int KEY_WORDS = 6;
    localparam int KEY_W     = KEY_WORDS * DW;
    localparam int BLK_BYTES = BLK_W / 8;

    localparam logic [7:0] A_KEY_TOP = 8'h14;
    localparam logic [7:0] A_IV_HI   = 8'h18;
    localparam logic [7:0] A_IV_LO   = 8'h1C;
    localparam logic [7:0] A_CTRL    = 8'h20;
    localparam logic [7:0] A_LEN     = 8'h24;
    localparam logic [7:0] A_DAT_HI  = 8'h28;
    localparam logic [7:0] A_DAT_LO  = 8'h2C;
    localparam logic [7:0] A_REV     = 8'h30;
    localparam logic [7:0] A_DMA     = 8'h34;
    localparam logic [7:0] A_ISTS    = 8'h3C;
    localparam logic [7:0] A_IEN     = 8'h40;

    typedef enum logic [1:0] {ST_IN, ST_RUN, ST_OUT} seq_state_e;

    typedef struct packed {
        logic cbc;
        logic triple;
        logic encrypt;
    } mode_t;

    typedef struct packed {
        logic out_en;
        logic in_en;
        logic go;
    } dma_cfg_t;

    // pair-swapped, descending from the top key address
    function automatic logic [7:0] key_addr(input int idx);
        return A_KEY_TOP - 8'((idx ^ 1) * 4);
    endfunction

    function automatic logic [31:0] rev_word(input logic [2:0] maj, input logic [5:0] mnr);
        return {21'b0, maj, 2'b0, mnr};
    endfunction
endpackage

// File: rtl/cfr_keybank.sv
module cfr_keybank
    import cfr_pkg::*;
#(
    parameter int WORDS = KEY_WORDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [DW-1:0]       wdata,
    output logic [WORDS*DW-1:0] key,
    output logic                hit,
    output logic [DW-1:0]       rdata
);
    logic [DW-1:0]    kw  [WORDS];
    logic [WORDS-1:0] sel;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign sel[i] = (addr == key_addr(i));
        always_ff @(posedge clk) begin
            if (rst)                kw[i] <= '0;
            else if (wr_en && sel[i]) kw[i] <= wdata;
        end
        assign key[i*DW +: DW] = kw[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++)
            if (sel[i]) rdata = kw[i];
        hit = |sel;
    end

    // R2
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(key));
endmodule

// File: rtl/cfr_chain.sv
module cfr_chain
    import cfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic [BLK_W-1:0] blk_in,
    input  logic             capture,
    input  logic [BLK_W-1:0] core_res,
    input  logic             iv_wr_hi,
    input  logic             iv_wr_lo,
    input  logic [DW-1:0]    wdata,
    output logic [BLK_W-1:0] core_din,
    output logic [BLK_W-1:0] iv,
    output logic [BLK_W-1:0] result
);
    logic whiten_in, whiten_out;

    assign whiten_in  = mode.cbc && mode.encrypt;
    assign whiten_out = mode.cbc && !mode.encrypt;
    assign core_din   = whiten_in ? (blk_in ^ iv) : blk_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            iv     <= '0;
            result <= '0;
        end else if (capture) begin
            result <= whiten_out ? (core_res ^ iv) : core_res;
            if (mode.cbc) iv <= mode.encrypt ? core_res : blk_in;
        end else begin
            if (iv_wr_hi) iv[BLK_W-1:DW] <= wdata;
            if (iv_wr_lo) iv[DW-1:0]     <= wdata;
        end
    end

    // R7
    iv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!capture && !iv_wr_hi && !iv_wr_lo) |=> $stable(iv));
endmodule

// File: rtl/cfr_seq.sv
module cfr_seq
    import cfr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          len_wr,
    input  logic [28:0]   len_val,
    input  logic          go_wr,
    input  logic          pop,
    input  logic          core_done,
    input  logic          sts_wr,
    input  logic          ien_wr,
    input  logic [1:0]    flag_wdata,
    input  dma_cfg_t      dma,
    output logic          core_start,
    output logic          blk_done,
    output logic          in_rdy,
    output logic          out_rdy,
    output logic [DW-1:0] remaining,
    output logic [1:0]    sts,
    output logic [1:0]    ien,
    output logic          irq,
    output logic          dma_in_req,
    output logic          dma_out_req
);
    seq_state_e state;
    logic       in_rdy_q;
    logic [1:0] sts_nx;

    assign in_rdy   = (state == ST_IN) && (remaining != '0);
    assign out_rdy  = (state == ST_OUT);
    assign blk_done = core_done && (state == ST_RUN);

    always_comb begin
        sts_nx = sts;
        if (sts_wr) sts_nx = sts_nx & flag_wdata;
        if (in_rdy && !in_rdy_q) sts_nx[0] = 1'b1;
        if (blk_done) sts_nx[1] = 1'b1;
        if (pop && out_rdy) sts_nx[1] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IN;
            remaining  <= '0;
            core_start <= 1'b0;
            in_rdy_q   <= 1'b0;
            sts        <= '0;
            ien        <= '0;
        end else begin
            core_start <= go_wr && in_rdy && !len_wr;
            in_rdy_q   <= in_rdy;
            sts        <= sts_nx;
            if (ien_wr) ien <= flag_wdata;
            if (len_wr) begin
                remaining <= {len_val, 3'b000};
                state     <= ST_IN;
            end else begin
                case (state)
                    ST_IN:  if (go_wr && in_rdy) state <= ST_RUN;
                    ST_RUN: if (core_done) state <= ST_OUT;
                    ST_OUT: if (pop) begin
                        remaining <= remaining - DW'(BLK_BYTES);
                        state     <= ST_IN;
                    end
                    default: state <= ST_IN;
                endcase
            end
        end
    end

    assign irq         = |(sts & ien);
    assign dma_in_req  = dma.go && dma.in_en && in_rdy;
    assign dma_out_req = dma.go && dma.out_en && out_rdy;

    // R5
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (state == ST_RUN));
    // R6
    out_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_rdy) |-> $past(core_done));
    // R9
    dout_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[1]) |-> $past(core_done));
    // R4
    rem_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((remaining != $past(remaining)) && !$past(len_wr)) |->
        (remaining == $past(remaining) - DW'(BLK_BYTES)));
endmodule

// File: rtl/cipher_reg_front.sv
module cipher_reg_front
    import cfr_pkg::*;
#(
    parameter int REV_MAJOR = 3,
    parameter int REV_MINOR = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq,
    output logic             dma_in_req,
    output logic             dma_out_req,
    output logic             core_start,
    output logic [KEY_W-1:0] core_key,
    output logic             core_triple,
    output logic             core_encrypt,
    output logic [BLK_W-1:0] core_din,
    input  logic             core_done,
    input  logic [BLK_W-1:0] core_dout
);
    localparam logic [DW-1:0] REV_VAL = rev_word(3'(REV_MAJOR), 6'(REV_MINOR));

    mode_t            mode;
    dma_cfg_t         dma;
    logic [BLK_W-1:0] blk, iv, result;
    logic             in_rdy, out_rdy, blk_done, key_hit;
    logic [DW-1:0]    key_rdata, remaining;
    logic [1:0]       sts, ien;

    function automatic logic wr_at(input logic [7:0] a);
        return bus_wr && (bus_addr == a);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            dma  <= '0;
            blk  <= '0;
        end else begin
            if (wr_at(A_CTRL)) mode <= mode_t'(bus_wdata[4:2]);
            if (wr_at(A_DMA))  dma  <= '{out_en: bus_wdata[6], in_en: bus_wdata[5], go: bus_wdata[0]};
            if (wr_at(A_DAT_HI) && in_rdy) blk[BLK_W-1:DW] <= bus_wdata;
            if (wr_at(A_DAT_LO) && in_rdy) blk[DW-1:0]     <= bus_wdata;
        end
    end

    cfr_keybank u_keys (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .key(core_key), .hit(key_hit), .rdata(key_rdata)
    );

    cfr_chain u_chain (
        .clk(clk), .rst(rst), .mode(mode), .blk_in(blk), .capture(blk_done),
        .core_res(core_dout), .iv_wr_hi(wr_at(A_IV_HI)), .iv_wr_lo(wr_at(A_IV_LO)),
        .wdata(bus_wdata), .core_din(core_din), .iv(iv), .result(result)
    );

    cfr_seq u_seq (
        .clk(clk), .rst(rst), .len_wr(wr_at(A_LEN)), .len_val(bus_wdata[31:3]),
        .go_wr(wr_at(A_DAT_LO)), .pop(bus_rd && (bus_addr == A_DAT_LO)),
        .core_done(core_done), .sts_wr(wr_at(A_ISTS)), .ien_wr(wr_at(A_IEN)),
        .flag_wdata(bus_wdata[2:1]), .dma(dma), .core_start(core_start),
        .blk_done(blk_done), .in_rdy(in_rdy), .out_rdy(out_rdy), .remaining(remaining),
        .sts(sts), .ien(ien), .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    assign core_triple  = mode.triple;
    assign core_encrypt = mode.encrypt;

    always_comb begin
        if (key_hit) bus_rdata = key_rdata;
        else begin
            case (bus_addr)
                A_IV_HI:  bus_rdata = iv[BLK_W-1:DW];
                A_IV_LO:  bus_rdata = iv[DW-1:0];
                A_CTRL:   bus_rdata = {27'b0, mode, in_rdy, out_rdy};
                A_LEN:    bus_rdata = remaining;
                A_DAT_HI: bus_rdata = result[BLK_W-1:DW];
                A_DAT_LO: bus_rdata = result[DW-1:0];
                A_REV:    bus_rdata = REV_VAL;
                A_DMA:    bus_rdata = {25'b0, dma.out_en, dma.in_en, 4'b0, dma.go};
                A_ISTS:   bus_rdata = {29'b0, sts, 1'b0};
                A_IEN:    bus_rdata = {29'b0, ien, 1'b0};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R11
    blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_rdy |=> $stable(blk));
endmodule

// File: tb/cipher_reg_front_bench.sv
module cipher_reg_front_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         irq, dma_in_req, dma_out_req, core_start, core_triple, core_encrypt;
    logic [191:0] core_key;
    logic [63:0]  core_din, core_dout;
    logic         core_done;

    int checks = 0, failures = 0, starts = 0, blocks = 0;
    logic [2:0]  cnt;
    logic [63:0] hold;

    always #10 clk = ~clk;  // 50 MHz

    cipher_reg_front u_cipher_reg_front (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_in_req(dma_in_req),
        .dma_out_req(dma_out_req), .core_start(core_start), .core_key(core_key),
        .core_triple(core_triple), .core_encrypt(core_encrypt), .core_din(core_din),
        .core_done(core_done), .core_dout(core_dout)
    );

    function automatic logic [63:0] stub_f(input logic [63:0] d, input logic [191:0] k,
                                           input logic trip, input logic enc);
        logic [63:0] r;
        r = enc ? {d[62:0], d[63]} : {d[0], d[63:1]};
        r = r ^ k[63:0] ^ (trip ? k[191:128] : 64'h0) ^ (enc ? 64'h0F0F_3C3C_0000_FFFF : 64'h5A5A_0000_A5A5_1234);
        return r;
    endfunction

    // stub cipher core: result valid three cycles after start
    always @(posedge clk) begin
        if (rst) cnt <= 3'd0;
        else if (core_start) begin
            cnt  <= 3'd3;
            hold <= stub_f(core_din, core_key, core_triple, core_encrypt);
            starts <= starts + 1;
        end else if (cnt != 0) cnt <= cnt - 3'd1;
    end
    assign core_done = (cnt == 3'd1);
    assign core_dout = hold;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic wait_out();
        logic [31:0] c;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); peek(8'h20, c);
            if (c[0]) break;
        end
    endtask

    task automatic run_block(input logic [63:0] b, output logic [63:0] r);
        logic [31:0] hi, lo;
        wr(8'h28, b[63:32]);
        wr(8'h2C, b[31:0]);
        wait_out();
        rd(8'h28, hi);
        rd(8'h2C, lo);
        r = {hi, lo};
        blocks++;
    endtask

    // vector table: mode {cbc,triple,encrypt}, two blocks, starting IV
    localparam logic [2:0]  VMODE [6] = '{3'b001, 3'b010, 3'b101, 3'b100, 3'b111, 3'b110};
    localparam logic [63:0] VB0 [6] = '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                                        64'h1111_2222_3333_4444, 64'hDEAD_BEEF_CAFE_F00D,
                                        64'h8000_0000_0000_0001, 64'h0F1E_2D3C_4B5A_6978};
    localparam logic [63:0] VB1 [6] = '{64'hA5A5_A5A5_5A5A_5A5A, 64'h0000_0000_0000_0000,
                                        64'h5555_6666_7777_8888, 64'h1234_5678_9ABC_DEF0,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'h8796_A5B4_C3D2_E1F0};
    localparam logic [63:0] VIV [6] = '{64'h0, 64'h1357_9BDF_2468_ACE0,
                                        64'hC001_D00D_0BAD_F00D, 64'h7777_0000_3333_9999,
                                        64'h0102_0304_0506_0708, 64'hABCD_EF01_2345_6789};

    logic [191:0] key_exp;
    logic [31:0]  d;
    logic [63:0]  r, iv_m, cin, res, exp_o;

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h20, d); chk("R1 ctrl", d, 0);
        rd(8'h24, d); chk("R1 len", d, 0);
        rd(8'h3C, d); chk("R1 ists", d, 0);
        rd(8'h10, d); chk("R1 key0", d, 0);
        chk("R1 outputs", {irq, core_start, dma_in_req, dma_out_req}, 0);
        // R12 revision
        rd(8'h30, d); chk("R12 rev", d, 32'h305);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, d); chk("R12 rev write ignored", d, 32'h305);
        // R2 key placement
        begin
            logic [7:0] ka [6] = '{8'h10, 8'h14, 8'h08, 8'h0C, 8'h00, 8'h04};
            for (int i = 0; i < 6; i++) begin
                wr(ka[i], 32'h1357_0000 + 32'(i) * 32'h0101_1011);
                key_exp[i*32 +: 32] = 32'h1357_0000 + 32'(i) * 32'h0101_1011;
            end
        end
        @(negedge clk); chk("R2 core_key", core_key, key_exp);
        rd(8'h08, d); chk("R2 word2 readback", d, key_exp[95:64]);
        // R3 control bits
        wr(8'h20, 32'h1F);
        rd(8'h20, d); chk("R3 ctrl readback", d, 32'h1C);
        chk("R3 core flags", {core_triple, core_encrypt}, 2'b11);
        // R4 length rounding
        wr(8'h24, 32'h17);
        rd(8'h24, d); chk("R4 length rounded", d, 32'h10);
        // R5 input ready and data-in event
        @(negedge clk);
        peek(8'h20, d); chk("R5 input ready", d[1:0], 2'b10);
        peek(8'h3C, d); chk("R9 data-in status", d, 32'h2);
        wr(8'h24, 32'h0);
        wr(8'h3C, 32'h0);

        // vector walk: R6/R7/R8 over modes and key sizes
        for (int v = 0; v < 6; v++) begin
            wr(8'h20, {27'b0, VMODE[v], 2'b00});
            wr(8'h18, VIV[v][63:32]);
            wr(8'h1C, VIV[v][31:0]);
            wr(8'h24, 32'd16);
            iv_m = VIV[v];
            for (int b = 0; b < 2; b++) begin
                cin = (b == 0) ? VB0[v] : VB1[v];
                if (VMODE[v][2] && VMODE[v][0]) begin
                    res = stub_f(cin ^ iv_m, key_exp, VMODE[v][1], 1'b1);
                    exp_o = res; iv_m = res;
                end else if (VMODE[v][2]) begin
                    res = stub_f(cin, key_exp, VMODE[v][1], 1'b0);
                    exp_o = res ^ iv_m; iv_m = cin;
                end else begin
                    exp_o = stub_f(cin, key_exp, VMODE[v][1], VMODE[v][0]);
                end
                run_block(cin, r);
                chk(VMODE[v][2] ? (VMODE[v][0] ? "R7 cbc enc block" : "R8 cbc dec block")
                                : "R6 ecb block", r, exp_o);
            end
            rd(8'h18, d); r[63:32] = d;
            rd(8'h1C, d); r[31:0] = d;
            chk(VMODE[v][2] ? "R7/R8 chaining vector" : "R6 iv untouched in ecb", r, iv_m);
            rd(8'h24, d); chk("R4 length used up", d, 0);
        end
        chk("R5 one start per block", 64'(starts), 64'(blocks));

        // R11 data writes during a block in flight are ignored (cbc decrypt)
        wr(8'h20, 32'h10);
        wr(8'h18, 32'h0BAD_CAFE);
        wr(8'h1C, 32'h1234_4321);
        wr(8'h24, 32'd8);
        wr(8'h28, 32'hAAAA_0001);
        wr(8'h2C, 32'hBBBB_0002);
        wr(8'h28, 32'h9999_9999);
        wait_out();
        peek(8'h20, d); chk("R6 output ready after done", d[1:0], 2'b01);
        rd(8'h28, d); rd(8'h2C, d);
        chk("R11 result unaffected", d,
            stub_f(64'hAAAA_0001_BBBB_0002, key_exp, 1'b0, 1'b0)[31:0] ^ 32'h1234_4321);
        rd(8'h18, d); chk("R11 vector unaffected", d, 32'hAAAA_0001);
        peek(8'h20, d); chk("R6 output ready cleared", d[1:0], 2'b00);

        // R9 interrupts
        wr(8'h3C, 32'h0);
        wr(8'h20, 32'h04);
        wr(8'h40, 32'h4);
        wr(8'h24, 32'd8);
        wr(8'h28, 32'h1); wr(8'h2C, 32'h2);
        @(negedge clk); chk("R9 irq masked", irq, 1'b0);
        wait_out(); @(negedge clk);
        chk("R9 irq on data-out", irq, 1'b1);
        peek(8'h3C, d); chk("R9 status both", d, 32'h6);
        wr(8'h3C, 32'h0);
        peek(8'h3C, d); chk("R9 write-zero clears", d, 32'h0);
        chk("R9 irq cleared", irq, 1'b0);
        rd(8'h2C, d);

        // R10 DMA requests
        wr(8'h34, 32'h61);
        wr(8'h24, 32'd8);
        @(negedge clk); chk("R10 in request", {dma_in_req, dma_out_req}, 2'b10);
        wr(8'h28, 32'h3); wr(8'h2C, 32'h4);
        wait_out(); @(negedge clk);
        chk("R10 out request", {dma_in_req, dma_out_req}, 2'b01);
        wr(8'h34, 32'h0);
        chk("R10 stop", {dma_in_req, dma_out_req}, 2'b00);
        rd(8'h2C, d);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule